// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an up-counting interval timer. On each active tick of the selected count source, the counter advances by one. When the count equals a programmed compare value, the next tick returns the counter to zero instead and raises a sticky interrupt request flag. The block therefore produces a request every compare+1 ticks.

Software drives the block through three write strobes:

- A control write loads the enable bit, a 3-bit source select and a mode bit.
- A compare write loads the compare register.
- A clear strobe drops the interrupt flag.

The live count is always visible on an output for readback.

The count source can be one of four:

- every system clock cycle;
- every fourth system clock cycle, from a free-running prescaler;
- an external tick that is already one system-clock pulse wide;
- an external clock line that is synchronized and edge-detected inside the block.

All state lives in the system clock domain. For this reason, a readback never sees a half-updated count.

Top module: `cmp_interval_timer`

## Requirements
- R1: After reset, `count_o` is 0x00 and `irq_o` is 0. The enable bit, the mode bit and the compare register reset to 0. The source select resets to 3'b000.
- R2: A control write that changes the enable bit from 0 to 1 sets the count to 0x00 at that clock edge. While the timer is stopped, the count holds its value unless R5 applies. The timer is stopped when enable is 0 or mode is 1.
- R3: While the timer is running, each active tick increments the count by one. On a tick where the count equals the compare value, the count instead returns to 0x00 and `irq_o` is set at the same edge.
- R4: If the compare value is written below the current count while the timer runs, the count keeps rising through 0xFF and wraps to 0x00. It then counts up to the compare value before the next match.
- R5: A compare write while the timer is stopped clears the count to 0x00 at the first active tick of the selected source after that write, and not before that tick.
- R6: The source select field decodes as follows:
  - 3'b000: every system clock cycle is a tick.
  - 3'b010: each cycle with `ext_tick_i` high is a tick.
  - 3'b1xx: no ticks.
- R7: `irq_o` stays set until a cycle with `irq_clr_i` high clears it. If a clear and a match fall in the same cycle, `irq_o` remains 1.
- R8: While the mode bit is 1, the timer counts nothing, even with enable at 1. Only mode 0 gives normal timer operation.
- R9: Source select 3'b001 gives exactly one tick in every four system clock cycles.
- R10: Source select 3'b011 gives exactly one tick for each rising edge of `ext_clk_i`. The tick follows a two-stage synchronizer and an edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Enable bit written by a control write |
| ctrl_sel_i | input | 3 | Count source select written by a control write |
| ctrl_mode_i | input | 1 | Mode bit written by a control write (0 = normal timer) |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_data_i | input | 8 | Compare value |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| ext_clk_i | input | 1 | Asynchronous external clock line (source 3'b011) |
| ext_tick_i | input | 1 | External tick, one system clock wide (source 3'b010) |
| count_o | output | 8 | Current counter value |
| irq_o | output | 1 | Interrupt request flag |

## Verification
The bench builds the timer with its default parameters:

- an 8-bit count;
- a 2-bit prescaler;
- a two-stage external synchronizer.

With an 8-bit count, the wrap through 0xFF after a lowered compare value takes only a few hundred cycles. That makes the overflow path cheap to drive to completion.

The 2-bit prescaler makes the divide-by-four spacing directly measurable between count changes. The two-stage synchronizer keeps the latency from an external edge to the count short enough to sample within a handful of cycles.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam logic [2:0] SEL_SYS      = 3'b000;
  localparam logic [2:0] SEL_DIV      = 3'b001;
  localparam logic [2:0] SEL_EXT_RAW  = 3'b010;
  localparam logic [2:0] SEL_EXT_SYNC = 3'b011;

  typedef struct packed {
    logic       en;
    logic [2:0] sel;
    logic       mode;
  } ctrl_t;

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned PRESC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  logic [PRESC_W-1:0] div_q;
  logic [PRESC_W-1:0] div_d;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign tick_o = &div_q;

endmodule

// File: rtl/cmt_ext_sync.sv
module cmt_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] chain_q;
  logic            last_q;

  assign chain_q[0] = async_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[i+1] <= 1'b0;
      end else begin
        chain_q[i+1] <= chain_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
    end else begin
      last_q <= chain_q[STAGES];
    end
  end

  assign rise_o = chain_q[STAGES] & ~last_q;

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             irq_q, irq_d;
  logic             hit;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    hit    = 1'b0;
    if (start_i) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (run_i) begin
      if (tick_i) begin
        if (cnt_q == cmp_i) begin
          cnt_d = '0;
          hit   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      if (tick_i) begin
        if (pend_q) begin
          cnt_d = '0;
        end
        pend_d = 1'b0;
      end
      if (cmp_we_i) begin
        pend_d = 1'b1;
      end
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (irq_clr_i) begin
      irq_d = 1'b0;
    end
    if (hit) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRESC_W     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             ctrl_en_i,
  input  logic [2:0]       ctrl_sel_i,
  input  logic             ctrl_mode_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             irq_clr_i,
  input  logic             ext_clk_i,
  input  logic             ext_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);

  localparam int unsigned RST_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  // control and compare registers
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;

  always_comb begin
    ctrl_d = ctrl_q;
    cmp_d  = cmp_q;
    if (ctrl_we_i) begin
      ctrl_d.en   = ctrl_en_i;
      ctrl_d.sel  = ctrl_sel_i;
      ctrl_d.mode = ctrl_mode_i;
    end
    if (cmp_we_i) begin
      cmp_d = cmp_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
    end
  end

  // count sources
  logic div_tick;
  logic sync_tick;
  logic tick;
  logic run;
  logic start;

  cmt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_o (div_tick)
  );

  cmt_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .async_i (ext_clk_i),
    .rise_o  (sync_tick)
  );

  always_comb begin
    case (ctrl_q.sel)
      SEL_SYS:      tick = 1'b1;
      SEL_DIV:      tick = div_tick;
      SEL_EXT_RAW:  tick = ext_tick_i;
      SEL_EXT_SYNC: tick = sync_tick;
      default:      tick = 1'b0;
    endcase
  end

  assign run   = ctrl_q.en & ~ctrl_q.mode;
  assign start = ctrl_we_i & ctrl_en_i & ~ctrl_q.en;

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .run_i     (run),
    .tick_i    (tick),
    .start_i   (start),
    .cmp_we_i  (cmp_we_i),
    .cmp_i     (cmp_q),
    .irq_clr_i (irq_clr_i),
    .cnt_o     (count_o),
    .irq_o     (irq_o)
  );

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             irq,
  input logic             clr,
  input logic             run,
  input logic             tick,
  input logic             start
);

  // R2: a stopped timer with no tick and no start keeps its count
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !tick && !start) |=> $stable(cnt));

  // R3: a non-matching tick while running adds one
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !start && cnt != cmp) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3: a matching tick returns the count to zero and raises the flag
  p_match_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !start && cnt == cmp) |=> (cnt == '0 && irq));

  // R7: the flag is sticky without a clear
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);

  // R7: a clear with no match drops the flag
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(run && tick && cnt == cmp)) |=> !irq);

  // R2: enabling from zero starts at zero
  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));

endmodule

bind cmp_interval_timer cmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_sync_n),
  .cnt   (count_o),
  .cmp   (cmp_q),
  .irq   (irq_o),
  .clr   (irq_clr_i),
  .run   (run),
  .tick  (tick),
  .start (start)
);

// File: tb/cmp_interval_timer_test.sv
module cmp_interval_timer_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_we, ctrl_en, ctrl_mode;
  logic [2:0] ctrl_sel;
  logic       cmp_we;
  logic [7:0] cmp_data;
  logic       irq_clr, ext_clk, ext_tick;
  logic [7:0] count;
  logic       irq;

  int tests = 0;
  int fails = 0;

  // bench model state
  logic [7:0] m_cnt, m_cmp;
  logic       m_irq, m_pend, m_en, m_mode;
  logic [2:0] m_sel;

  always #5 clk = ~clk;

  cmp_interval_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en),
    .ctrl_sel_i(ctrl_sel), .ctrl_mode_i(ctrl_mode), .cmp_we_i(cmp_we),
    .cmp_data_i(cmp_data), .irq_clr_i(irq_clr), .ext_clk_i(ext_clk),
    .ext_tick_i(ext_tick), .count_o(count), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic model_tick(input logic [2:0] sel, input logic xt);
    if (sel == 3'b000) return 1'b1;
    if (sel == 3'b010) return xt;
    return 1'b0;
  endfunction

  // one clock: advance the model from the driven inputs, then compare
  task automatic cyc(input string tag);
    logic tk, run, st, hit;
    logic [7:0] n_cnt;
    logic n_pend, n_irq;
    tk  = model_tick(m_sel, ext_tick);
    run = m_en && !m_mode;
    st  = ctrl_we && ctrl_en && !m_en;
    hit = 1'b0;
    n_cnt = m_cnt;
    n_pend = m_pend;
    if (st) begin
      n_cnt = 8'h00; n_pend = 1'b0;
    end else if (run) begin
      if (tk) begin
        if (m_cnt == m_cmp) begin n_cnt = 8'h00; hit = 1'b1; end
        else n_cnt = m_cnt + 8'h01;
      end
    end else begin
      if (tk) begin
        if (m_pend) n_cnt = 8'h00;
        n_pend = 1'b0;
      end
      if (cmp_we) n_pend = 1'b1;
    end
    n_irq = hit ? 1'b1 : (irq_clr ? 1'b0 : m_irq);
    @(posedge clk);
    m_cnt = n_cnt; m_pend = n_pend; m_irq = n_irq;
    if (ctrl_we) begin m_en = ctrl_en; m_sel = ctrl_sel; m_mode = ctrl_mode; end
    if (cmp_we) m_cmp = cmp_data;
    #2;
    chk({tag, " count"}, count, m_cnt);
    chk({tag, " irq"}, irq, m_irq);
    ctrl_we = 0; cmp_we = 0; irq_clr = 0; ext_tick = 0;
  endtask

  task automatic do_reset();
    ctrl_we = 0; ctrl_en = 0; ctrl_mode = 0; ctrl_sel = 0; cmp_we = 0;
    cmp_data = 0; irq_clr = 0; ext_clk = 0; ext_tick = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    m_cnt = 0; m_cmp = 0; m_irq = 0; m_pend = 0; m_en = 0; m_mode = 0; m_sel = 0;
  endtask

  task automatic wr_ctrl(input logic en, input logic [2:0] sel, input logic mode);
    ctrl_we = 1; ctrl_en = en; ctrl_sel = sel; ctrl_mode = mode;
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    cmp_we = 1; cmp_data = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    do_reset();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);

    // R3 basic interval with compare 3, system clock source
    wr_cmp(8'd3); cyc("R3");
    wr_ctrl(1, 3'b000, 0); cyc("R2");
    repeat (12) cyc("R3");

    // R7 clear pulses every cycle, colliding with matches
    repeat (10) begin irq_clr = 1; cyc("R7"); end
    irq_clr = 1; cyc("R7");
    chk("R7 collision", irq, m_irq);

    // R4 compare lowered below count
    wr_cmp(8'd200); cyc("R4");
    repeat (15) cyc("R4");
    wr_cmp(8'd5); cyc("R4");
    repeat (250) cyc("R4");
    repeat (10) cyc("R4");

    // R8 mode bit holds counting
    wr_ctrl(1, 3'b000, 1); cyc("R8");
    repeat (8) cyc("R8");
    chk("R8 held", count, m_cnt);

    // R5 compare write while stopped, raw external source
    wr_ctrl(0, 3'b010, 0); cyc("R5");
    wr_cmp(8'd9); cyc("R5");
    repeat (5) cyc("R5");
    chk("R5 no tick yet", count, m_cnt);
    ext_tick = 1; cyc("R5");
    chk("R5 cleared", count, 0);

    // R6 upper selects never tick
    wr_ctrl(1, 3'b100, 0); cyc("R6");
    repeat (6) cyc("R6");
    chk("R6 idle", count, 0);

    // R6 random traffic on sources 000 and 010
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) wr_ctrl($urandom_range(0, 1), ($urandom_range(0, 1) != 0) ? 3'b010 : 3'b000,
                         ($urandom_range(0, 9) == 0));
      if (r >= 4 && r < 8) wr_cmp(8'($urandom_range(0, 40)));
      if (r >= 8 && r < 14) irq_clr = 1;
      ext_tick = ($urandom_range(0, 2) == 0);
      cyc("R6");
    end

    // R9 divide-by-four spacing
    do_reset();
    cmp_we = 1; cmp_data = 8'hFF;
    @(posedge clk); #2 cmp_we = 0;
    ctrl_we = 1; ctrl_en = 1; ctrl_sel = 3'b001; ctrl_mode = 0;
    @(posedge clk); #2 ctrl_we = 0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] prev;
      int n;
      prev = count; n = 0;
      do begin @(posedge clk); #2; n++; end while (count == prev && n < 20);
      if (k > 0) chk("R9 spacing", n, 4);
    end

    // R10 synchronized external clock edges
    do_reset();
    cmp_we = 1; cmp_data = 8'hFF;
    @(posedge clk); #2 cmp_we = 0;
    ctrl_we = 1; ctrl_en = 1; ctrl_sel = 3'b011; ctrl_mode = 0;
    @(posedge clk); #2 ctrl_we = 0;
    chk("R10 start", count, 0);
    for (int e = 0; e < 5; e++) begin
      ext_clk = 1; repeat (6) @(posedge clk); #2;
      ext_clk = 0; repeat (6) @(posedge clk); #2;
    end
    repeat (6) @(posedge clk); #2;
    chk("R10 edges", count, 5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule